// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block keeps the run state, error state and event outputs of a single DMA channel. A trigger (a non-null write to the channel's trigger register, or a chain pulse from another channel) starts a transfer sequence and raises `busy`. While the sequence runs, `issue_ok` tells the address and data machinery that it may issue transfers. When that machinery reports the final transfer through `last_done`, the sequence ends. The block then pulses a chain trigger toward the channel held in its chain-target field and, in normal mode, pulses the interrupt.

The enable input pauses the channel without losing the sequence: `busy` holds while issuing stops. A read or write bus error sets its own sticky flag, halts the channel, and always raises the interrupt. New triggers stay blocked until software clears the flags by writing one. In quiet mode the end of a block is silent, and the interrupt comes instead from a null write to the trigger register, which marks the end of a control-block chain.

Top module: `dma_chan_seq`

## Requirements
- R1: A trigger (`trig_wr` with `trig_null`=0, or `chain_in`) sampled while `cfg_en`=1, `busy`=0 and no error flag is set makes `busy` 1 after that clock edge. `last_done` sampled while `issue_ok`=1 makes `busy` 0 after that edge.
- R2: While `cfg_en`=0, `issue_ok` is 0, and triggers and `last_done` have no effect. `busy` keeps its value, and the sequence completes normally once `cfg_en` returns to 1.
- R3: A completion pulses `chain_out` for one cycle after the completing edge, with only bit k set, where k is the chain-target value and bit k stands for channel k. When the target equals the parameter `CH_ID`, `chain_out` stays all zero.
- R4: The chain target (`chain_tgt`) resets to 0 and takes `cfg_tgt_data` on a clock edge where `cfg_tgt_wr`=1. A completion on the same edge uses the old value.
- R5: An `rd_err` pulse sets `rd_err_flag`, and a `wr_err` pulse sets `wr_err_flag`. Each flag stays set until its clear input (`clr_rd_err`, `clr_wr_err`) is 1 at an edge. A set and a clear on the same edge leave the flag set.
- R6: `any_err` equals `rd_err_flag` OR `wr_err_flag`.
- R7: A bus error pulse clears `busy` after that edge and pulses `irq` in the next cycle in either mode. While any flag is set, `issue_ok` is 0 and triggers are ignored.
- R8: With `cfg_quiet`=0, a completion pulses `irq` for exactly one cycle after the completing edge.
- R9: With `cfg_quiet`=1, a completion raises no `irq`, and a null trigger write (`trig_wr`=1, `trig_null`=1) pulses `irq` one cycle later. A null trigger write never starts a sequence in either mode.
- R10: A trigger sampled while `busy`=1 does not restart or end the sequence. `last_done` sampled while `busy`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Channel enable; 0 pauses the channel |
| cfg_quiet | input | 1 | Quiet interrupt mode |
| cfg_tgt_wr | input | 1 | Write strobe for the chain target |
| cfg_tgt_data | input | CHW | New chain target value |
| trig_wr | input | 1 | Write to the trigger register |
| trig_null | input | 1 | The trigger write carried a zero value |
| chain_in | input | 1 | Chain trigger arriving from another channel |
| last_done | input | 1 | Final transfer of the sequence completed |
| rd_err | input | 1 | Read bus error pulse |
| wr_err | input | 1 | Write bus error pulse |
| clr_rd_err | input | 1 | Write-one-to-clear of the read error flag |
| clr_wr_err | input | 1 | Write-one-to-clear of the write error flag |
| busy | output | 1 | A transfer sequence is in progress |
| issue_ok | output | 1 | Transfers may be issued this cycle |
| rd_err_flag | output | 1 | Sticky read error flag |
| wr_err_flag | output | 1 | Sticky write error flag |
| any_err | output | 1 | OR of the two error flags |
| irq | output | 1 | Channel interrupt pulse |
| chain_out | output | NUM_CH | One-hot chain trigger pulse, bit k for channel k |
| chain_tgt | output | CHW | Current chain target |

## Verification
The bench builds the block with `NUM_CH`=4 and `CH_ID`=2. With that choice the reset target of 0 is a real foreign channel, so the reset-default chain pulse can be seen. Target 2 reaches the self-suppression case, and target 3 drives the top bit of the chain vector. A cycle-level model built from the requirements predicts every output after each driven cycle. The model covers pauses in mid-sequence, errors colliding with clears and with completions, and the quiet-mode null trigger.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  // index of each sticky error flag in the flag vector
  localparam int ERR_RD = 0;
  localparam int ERR_WR = 1;
  localparam int ERR_N  = 2;

  // a trigger that may start a sequence: a non-null register write or a chain pulse
  function automatic logic start_request(input logic wr, input logic is_null, input logic chained);
    return (wr && !is_null) || chained;
  endfunction

  // interrupt causes: bus errors always; completion only outside quiet mode;
  // a null trigger write only inside quiet mode
  function automatic logic irq_cause(input logic err_evt, input logic done_evt,
                                     input logic null_evt, input logic quiet);
    return err_evt || (done_evt && !quiet) || (null_evt && quiet);
  endfunction

  // next value of a sticky flag; a set beats a clear on the same edge
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set || (cur && !clr);
  endfunction

endpackage

// File: rtl/dma_seq_errflags.sv
module dma_seq_errflags
  import dma_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_N-1:0] set_vec,
  input  logic [ERR_N-1:0] clr_vec,
  output logic [ERR_N-1:0] flag_vec
);

  for (genvar i = 0; i < ERR_N; i++) begin : g_flag
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= sticky_next(flag_q, set_vec[i], clr_vec[i]);
    end

    assign flag_vec[i] = flag_q;

    // R5: a flag holds until its clear arrives
    a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !clr_vec[i] |=> flag_q);
    // R5: a set always lands, even against a clear
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flag_q);
  end

endmodule

// File: rtl/dma_seq_runctl.sv
module dma_seq_runctl
  import dma_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic err_any,
  input  logic err_evt,
  input  logic trig,
  input  logic last_done,
  output logic busy,
  output logic issue_ok,
  output logic start_evt,
  output logic done_evt
);

  logic busy_q;
  logic busy_d;
  logic can_act;

  assign can_act   = en && !err_any;
  assign issue_ok  = busy_q && can_act;
  assign done_evt  = issue_ok && last_done && !err_evt;
  assign start_evt = !busy_q && can_act && trig && !err_evt;

  always_comb begin
    busy_d = busy_q;
    if (err_evt)        busy_d = 1'b0;
    else if (done_evt)  busy_d = 1'b0;
    else if (start_evt) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign busy = busy_q;

  // R1: busy only rises after an enabled trigger
  a_r1_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(trig && en));
  // R2: a paused busy channel stays busy
  a_r2_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !en && !err_evt |=> busy_q);
  // R7: a bus error halts the channel
  a_r7_halt: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> !busy_q);
  // R10: a running sequence ends only on completion or error
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !done_evt && !err_evt |=> busy_q);

endmodule

// File: rtl/dma_seq_chain.sv
module dma_seq_chain #(
  parameter int NUM_CH = 12,
  parameter int CH_ID  = 0,
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgt_wr,
  input  logic [CHW-1:0]    tgt_data,
  input  logic              done_evt,
  output logic [CHW-1:0]    tgt,
  output logic [NUM_CH-1:0] chain_vec
);

  logic [CHW-1:0]    tgt_q;
  logic [NUM_CH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_wr) tgt_q <= tgt_data;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_bit
    if (k == CH_ID) begin : g_self
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[k] <= 1'b0;
        else        chain_q[k] <= 1'b0;
      end
    end else begin : g_other
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[k] <= 1'b0;
        else        chain_q[k] <= done_evt && (tgt_q == CHW'(k));
      end
    end
  end

  assign tgt       = tgt_q;
  assign chain_vec = chain_q;

  // R3: at most one channel is triggered
  a_r3_chain_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chain_q));
  // R3: a chain pulse only follows a completion
  a_r3_chain_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|chain_q) |-> $past(done_evt));
  // R3: a chain pulse lasts a single cycle
  a_r3_chain_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|chain_q) && !done_evt |=> !(|chain_q));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int CH_ID  = 0,
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_quiet,
  input  logic              cfg_tgt_wr,
  input  logic [CHW-1:0]    cfg_tgt_data,
  input  logic              trig_wr,
  input  logic              trig_null,
  input  logic              chain_in,
  input  logic              last_done,
  input  logic              rd_err,
  input  logic              wr_err,
  input  logic              clr_rd_err,
  input  logic              clr_wr_err,
  output logic              busy,
  output logic              issue_ok,
  output logic              rd_err_flag,
  output logic              wr_err_flag,
  output logic              any_err,
  output logic              irq,
  output logic [NUM_CH-1:0] chain_out,
  output logic [CHW-1:0]    chain_tgt
);

  // named internal events, used by the assertions
  logic             err_evt;
  logic             null_evt;
  logic             trig_any;
  logic             start_evt;
  logic             done_evt;
  logic [ERR_N-1:0] err_set;
  logic [ERR_N-1:0] err_clr;
  logic [ERR_N-1:0] err_flags;
  logic             irq_q;

  assign err_evt  = rd_err || wr_err;
  assign null_evt = trig_wr && trig_null;
  assign trig_any = start_request(trig_wr, trig_null, chain_in);

  assign err_set[ERR_RD] = rd_err;
  assign err_set[ERR_WR] = wr_err;
  assign err_clr[ERR_RD] = clr_rd_err;
  assign err_clr[ERR_WR] = clr_wr_err;

  dma_seq_errflags u_err (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (err_set),
    .clr_vec  (err_clr),
    .flag_vec (err_flags)
  );

  dma_seq_runctl u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .err_any   (|err_flags),
    .err_evt   (err_evt),
    .trig      (trig_any),
    .last_done (last_done),
    .busy      (busy),
    .issue_ok  (issue_ok),
    .start_evt (start_evt),
    .done_evt  (done_evt)
  );

  dma_seq_chain #(
    .NUM_CH (NUM_CH),
    .CH_ID  (CH_ID)
  ) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_wr    (cfg_tgt_wr),
    .tgt_data  (cfg_tgt_data),
    .done_evt  (done_evt),
    .tgt       (chain_tgt),
    .chain_vec (chain_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_cause(err_evt, done_evt, null_evt, cfg_quiet);
  end

  assign irq         = irq_q;
  assign rd_err_flag = err_flags[ERR_RD];
  assign wr_err_flag = err_flags[ERR_WR];
  assign any_err     = |err_flags;

  // R7: every bus error raises the interrupt, quiet or not
  a_r7_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> irq);
  // R7: no transfer is issued while an error is pending
  a_r7_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err_flag || wr_err_flag) |-> !issue_ok);
  // R8: a normal-mode completion raises the interrupt
  a_r8_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !cfg_quiet |=> irq);
  // R9: a quiet completion stays silent
  a_r9_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && cfg_quiet && !err_evt && !null_evt |=> !irq);
  // R9: a null trigger write never starts a sequence
  a_r9_null_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    null_evt && !chain_in |-> !start_evt);

endmodule

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 4;
  localparam int CH_ID      = 2;
  localparam int CHW        = 2;

  typedef struct {
    string          tag;
    logic [12:0]    obs;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b1, cfg_quiet = 1'b0, cfg_tgt_wr = 1'b0;
  logic [CHW-1:0] cfg_tgt_data = '0;
  logic trig_wr = 1'b0, trig_null = 1'b0, chain_in = 1'b0, last_done = 1'b0;
  logic rd_err = 1'b0, wr_err = 1'b0, clr_rd_err = 1'b0, clr_wr_err = 1'b0;
  logic busy, issue_ok, rd_err_flag, wr_err_flag, any_err, irq;
  logic [NUM_CH-1:0] chain_out;
  logic [CHW-1:0]    chain_tgt;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];

  // requirement-level model state
  logic m_busy = 1'b0, m_rd = 1'b0, m_wr = 1'b0;
  logic [CHW-1:0] m_tgt = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_chan_seq #(.NUM_CH(NUM_CH), .CH_ID(CH_ID)) u_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_quiet(cfg_quiet),
    .cfg_tgt_wr(cfg_tgt_wr), .cfg_tgt_data(cfg_tgt_data), .trig_wr(trig_wr),
    .trig_null(trig_null), .chain_in(chain_in), .last_done(last_done),
    .rd_err(rd_err), .wr_err(wr_err), .clr_rd_err(clr_rd_err), .clr_wr_err(clr_wr_err),
    .busy(busy), .issue_ok(issue_ok), .rd_err_flag(rd_err_flag), .wr_err_flag(wr_err_flag),
    .any_err(any_err), .irq(irq), .chain_out(chain_out), .chain_tgt(chain_tgt)
  );

  function automatic logic [12:0] pack(logic b, logic io, logic r, logic w, logic a,
                                       logic i, logic [NUM_CH-1:0] c, logic [CHW-1:0] t);
    return {b, io, r, w, a, i, c, t};
  endfunction

  // driver: applies one cycle of stimulus and pushes the predicted outputs
  task automatic step(string tag);
    logic err_e, ok, st, dn, start_q, irq_e, n_busy, n_rd, n_wr;
    logic [NUM_CH-1:0] ch;
    exp_t e;
    err_e   = rd_err || wr_err;
    ok      = cfg_en && !(m_rd || m_wr);
    st      = (trig_wr && !trig_null) || chain_in;
    dn      = m_busy && ok && last_done && !err_e;
    start_q = !m_busy && ok && st && !err_e;
    irq_e   = err_e || (dn && !cfg_quiet) || (trig_wr && trig_null && cfg_quiet);
    ch      = (dn && (int'(m_tgt) != CH_ID)) ? NUM_CH'(1) << m_tgt : '0;
    n_busy  = err_e ? 1'b0 : (dn ? 1'b0 : (start_q ? 1'b1 : m_busy));
    n_rd    = rd_err || (m_rd && !clr_rd_err);
    n_wr    = wr_err || (m_wr && !clr_wr_err);
    if (cfg_tgt_wr) m_tgt = cfg_tgt_data;
    m_busy = n_busy; m_rd = n_rd; m_wr = n_wr;
    e.tag = tag;
    e.obs = pack(m_busy, m_busy && cfg_en && !(m_rd || m_wr), m_rd, m_wr, m_rd || m_wr,
                 irq_e, ch, m_tgt);
    sb.push_back(e);
    @(negedge clk);
    trig_wr = 0; trig_null = 0; chain_in = 0; last_done = 0; cfg_tgt_wr = 0;
    rd_err = 0; wr_err = 0; clr_rd_err = 0; clr_wr_err = 0;
  endtask

  // monitor: compares after each active edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      logic [12:0] act;
      e = sb.pop_front();
      act = pack(busy, issue_ok, rd_err_flag, wr_err_flag, any_err, irq, chain_out, chain_tgt);
      checks++;
      if (act !== e.obs) begin
        errors++;
        $display("FAIL %s: actual %b expected %b (busy,issue,rd,wr,any,irq,chain,tgt)",
                 e.tag, act, e.obs);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4: reset state, target 0
    checks++;
    if ({busy, issue_ok, any_err, irq, chain_out, chain_tgt} !== '0) begin
      errors++;
      $display("FAIL R4 reset: actual %b expected 0",
               {busy, issue_ok, any_err, irq, chain_out, chain_tgt});
    end
    trig_wr = 1;                  step("R1 trigger start");
                                  step("R1 running");
    trig_wr = 1;                  step("R10 trigger while busy");
    last_done = 1;                step("R3 R4 R8 done chains to reset target 0");
    last_done = 1;                step("R10 done while idle");
    chain_in = 1;                 step("R1 chain start");
    cfg_en = 0;                   step("R2 paused");
    last_done = 1;                step("R2 done ignored while paused");
    cfg_en = 1; last_done = 1;    step("R2 resume and complete");
    cfg_en = 0; trig_wr = 1;      step("R2 trigger ignored while disabled");
    cfg_en = 1;
    cfg_tgt_wr = 1; cfg_tgt_data = 2'd3; trig_wr = 1; step("R4 target write");
    last_done = 1;                step("R3 chain to 3");
    cfg_tgt_wr = 1; cfg_tgt_data = 2'd2; trig_wr = 1; step("R4 self target");
    last_done = 1;                step("R3 self target suppressed");
    cfg_quiet = 1; trig_wr = 1;   step("R9 quiet start");
    last_done = 1;                step("R9 quiet done silent");
    trig_wr = 1; trig_null = 1;   step("R9 null trigger irq");
    cfg_quiet = 0; trig_wr = 1; trig_null = 1; step("R9 null trigger normal mode");
    trig_wr = 1;                  step("R1 start before error");
    rd_err = 1; last_done = 1;    step("R7 R6 read error halts");
    trig_wr = 1;                  step("R7 trigger blocked by error");
    wr_err = 1; clr_rd_err = 1;   step("R5 R6 write error with read clear");
    wr_err = 1; clr_wr_err = 1;   step("R5 set wins over clear");
    clr_wr_err = 1;               step("R5 write clear");
    cfg_quiet = 1; rd_err = 1;    step("R7 error irq in quiet mode");
    clr_rd_err = 1; cfg_quiet = 0; step("R5 read clear");
    trig_wr = 1;                  step("R7 trigger accepted after clear");
    last_done = 1;                step("R8 normal done irq");
                                  step("R8 irq single pulse");
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule